// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small data-side translation cache for a 32-bit virtual address space with 4 KB pages. A lookup presents a 20-bit virtual page number and a 12-bit page offset. One cycle later the block answers with a hit, giving the physical address and the cached entry word, or with a miss. A miss tells an external page walker whether the directory entry covering the address must also be fetched. When the directory entry is already cached, the miss carries it back so the walker can skip that memory read.

The walker returns results through a separate, valid-qualified fill port, normally in the cycle after the miss. Each stored entry is tagged as either a directory entry or a leaf entry, and the two kinds never match each other. Two flush inputs are provided:
- A context flush invalidates every entry except those marked global.
- A full flush invalidates everything.

Victims are chosen within a set. An invalid way is taken first. Otherwise a tree pseudo-LRU picks the way.

Top module: `tlb_sa`

## Requirements
- R1: The array has 16 sets of 4 ways. A leaf entry for page number V lives in set V[3:0] with tag V[19:4]. A directory entry for V lives in set V[13:10] with tag V[19:14].
- R2: A lookup accepted on one clock edge produces its response (valid flag with exactly one of hit or miss) on the next edge. Without a lookup, the response valid, hit and miss outputs are 0.
- R3: On a hit, the physical address is entry word bits [31:12] joined to the unchanged 12-bit offset, and the full entry word is returned.
- R4: On a miss, need-directory is 1 when no directory entry for V[19:10] is cached. Otherwise need-directory is 0 and the cached directory word is returned.
- R5: A fill writes valid, kind, tag and word. A fill whose kind and key already exist overwrites that way instead of taking a new one.
- R6: A new fill takes the lowest-numbered invalid way of its set. If all ways are valid, it takes the tree victim. With tree bits b0, b1 and b2, the victim is way 0 or 1 (selected by b1) when b0=0, and way 2 or 3 (selected by b2) when b0=1.
- R7: A leaf hit or a fill marks its way as recently used by pointing the tree bits away from it. When both touch the same set in one cycle, the fill decides.
- R8: The context flush clears every valid bit except where entry word bit 8 (global) is 1.
- R9: The full flush clears all valid bits in one cycle, including global entries.
- R10: A fill in the same cycle as either flush is dropped. A lookup in the same cycle as a fill or flush sees the contents from before that edge.
- R11: After reset, all entries are invalid and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_offset | input | 12 | Page offset passed through to the physical address |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | 20 | Page number the fill belongs to |
| fill_is_dir | input | 1 | 1 = directory entry, 0 = leaf entry |
| fill_entry | input | 32 | Entry word to cache |
| flush_ctx | input | 1 | Context flush that keeps global entries |
| flush_all | input | 1 | Full flush |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Leaf entry found |
| rsp_miss | output | 1 | Leaf entry absent |
| rsp_need_dir | output | 1 | Directory entry also absent |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_entry | output | 32 | Cached leaf word on a hit, else 0 |
| rsp_dir_entry | output | 32 | Cached directory word on a miss with a directory hit, else 0 |

## Verification
The bench builds the block with its default sizes, 16 sets of 4 ways. Random page numbers are drawn from a narrow pool, so a few sets and directory keys are hit over and over. This reaches full sets, tree-driven eviction, directory and leaf entries sharing a set, and refills of keys that are already cached. Directed sequences add eviction order, global survival across a context flush, a flush colliding with a fill, and a lookup colliding with a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int VPN_W      = 20;
   localparam int OFS_W      = 12;
   localparam int WORD_W     = 32;
   localparam int DIR_W      = 10;
   localparam int GLOBAL_BIT = 8;

   typedef struct packed {
      logic              valid;
      logic              is_dir;
      logic [VPN_W-1:0]  tag;
      logic [WORD_W-1:0] word;
   } tlb_entry_t;
endpackage

// File: rtl/tlb_plru.sv
module tlb_plru #(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim
);
   generate
      if (WAYS == 4) begin : g_tree4
         logic [2:0] bits_q;
         always_comb begin
            if (bits_q[0]) victim = bits_q[2] ? WAY_W'(3) : WAY_W'(2);
            else           victim = bits_q[1] ? WAY_W'(1) : WAY_W'(0);
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bits_q <= '0;
            end else if (touch_en) begin
               bits_q[0] <= ~touch_way[1];
               if (!touch_way[1]) bits_q[1] <= ~touch_way[0];
               else               bits_q[2] <= ~touch_way[0];
            end
         end
      end else if (WAYS == 2) begin : g_tree2
         logic bit_q;
         assign victim = bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (touch_en) bit_q <= ~touch_way[0];
         end
      end else begin : g_bad_ways
         $error("tlb_plru: WAYS must be 2 or 4");
      end
   endgenerate
endmodule

// File: rtl/tlb_match.sv
module tlb_match
   import tlb_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  tlb_entry_t [WAYS-1:0] set_i,
   input  logic [VPN_W-1:0]      key_tag,
   input  logic                  want_dir,
   output logic                  hit,
   output logic [WAY_W-1:0]      way,
   output logic [WORD_W-1:0]     word
);
   always_comb begin
      hit  = 1'b0;
      way  = '0;
      word = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (set_i[w].valid && set_i[w].is_dir == want_dir && set_i[w].tag == key_tag) begin
            hit  = 1'b1;
            way  = WAY_W'(w);
            word = set_i[w].word;
         end
      end
   end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
   import tlb_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [OFS_W-1:0]  lk_offset,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic              fill_is_dir,
   input  logic [WORD_W-1:0] fill_entry,
   input  logic              flush_ctx,
   input  logic              flush_all,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_need_dir,
   output logic [WORD_W-1:0] rsp_paddr,
   output logic [WORD_W-1:0] rsp_entry,
   output logic [WORD_W-1:0] rsp_dir_entry
);
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int PPN_W = WORD_W - OFS_W;

   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("tlb_sa: SETS must be a power of two");
   end
   if (IDX_W > DIR_W) begin : g_bad_idx
      $error("tlb_sa: set index wider than the directory key");
   end

   tlb_entry_t [WAYS-1:0] mem_q [SETS];

   // key derivation: leaf keys from the whole page number, directory keys from its top bits
   function automatic logic [IDX_W-1:0] key_idx(input logic [VPN_W-1:0] v, input logic d);
      return d ? v[VPN_W-DIR_W +: IDX_W] : v[IDX_W-1:0];
   endfunction
   function automatic logic [VPN_W-1:0] key_tag(input logic [VPN_W-1:0] v, input logic d);
      logic [DIR_W-1:0] dk;
      dk = v[VPN_W-1 -: DIR_W];
      return d ? VPN_W'(dk >> IDX_W) : (v >> IDX_W);
   endfunction

   logic [IDX_W-1:0]  leaf_idx, dir_idx, fill_idx;
   logic [VPN_W-1:0]  leaf_tag, dir_tag, fill_tag;
   logic              leaf_hit, dir_hit, fill_hit;
   logic [WAY_W-1:0]  leaf_way, dir_way, fill_mway;
   logic [WORD_W-1:0] leaf_word, dir_word, fill_mword;

   assign leaf_idx = key_idx(lk_vpn, 1'b0);
   assign leaf_tag = key_tag(lk_vpn, 1'b0);
   assign dir_idx  = key_idx(lk_vpn, 1'b1);
   assign dir_tag  = key_tag(lk_vpn, 1'b1);
   assign fill_idx = key_idx(fill_vpn, fill_is_dir);
   assign fill_tag = key_tag(fill_vpn, fill_is_dir);

   tlb_match #(.WAYS(WAYS), .WAY_W(WAY_W)) i_leaf_match (
      .set_i(mem_q[leaf_idx]), .key_tag(leaf_tag), .want_dir(1'b0),
      .hit(leaf_hit), .way(leaf_way), .word(leaf_word));

   tlb_match #(.WAYS(WAYS), .WAY_W(WAY_W)) i_dir_match (
      .set_i(mem_q[dir_idx]), .key_tag(dir_tag), .want_dir(1'b1),
      .hit(dir_hit), .way(dir_way), .word(dir_word));

   tlb_match #(.WAYS(WAYS), .WAY_W(WAY_W)) i_fill_match (
      .set_i(mem_q[fill_idx]), .key_tag(fill_tag), .want_dir(fill_is_dir),
      .hit(fill_hit), .way(fill_mway), .word(fill_mword));

   // victim choice for the fill set
   logic [WAY_W-1:0] tree_victim [SETS];
   logic             free_any;
   logic [WAY_W-1:0] free_way, fill_way;
   logic             fill_ok;

   always_comb begin
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!mem_q[fill_idx][w].valid) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
      if (fill_hit)      fill_way = fill_mway;
      else if (free_any) fill_way = free_way;
      else               fill_way = tree_victim[fill_idx];
   end

   assign fill_ok = fill_valid && !flush_ctx && !flush_all;

   genvar gs;
   generate
      for (gs = 0; gs < SETS; gs++) begin : g_set
         logic             t_fill, t_hit;
         logic [WAY_W-1:0] t_way;
         assign t_fill = fill_ok && (fill_idx == IDX_W'(gs));
         assign t_hit  = lk_valid && leaf_hit && (leaf_idx == IDX_W'(gs));
         assign t_way  = t_fill ? fill_way : leaf_way;
         tlb_plru #(.WAYS(WAYS), .WAY_W(WAY_W)) i_plru (
            .clk(clk), .rst_n(rst_n), .touch_en(t_fill || t_hit),
            .touch_way(t_way), .victim(tree_victim[gs]));
      end
   endgenerate

   // storage update: full flush over context flush over fill
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               mem_q[s][w] <= '0;
      end else if (flush_all) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               mem_q[s][w].valid <= 1'b0;
      end else if (flush_ctx) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               mem_q[s][w].valid <= mem_q[s][w].valid & mem_q[s][w].word[GLOBAL_BIT];
      end else if (fill_valid) begin
         mem_q[fill_idx][fill_way] <= '{valid: 1'b1, is_dir: fill_is_dir,
                                        tag: fill_tag, word: fill_entry};
      end
   end

   // registered response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_miss      <= 1'b0;
         rsp_need_dir  <= 1'b0;
         rsp_paddr     <= '0;
         rsp_entry     <= '0;
         rsp_dir_entry <= '0;
      end else begin
         rsp_valid     <= lk_valid;
         rsp_hit       <= lk_valid && leaf_hit;
         rsp_miss      <= lk_valid && !leaf_hit;
         rsp_need_dir  <= lk_valid && !leaf_hit && !dir_hit;
         rsp_paddr     <= (lk_valid && leaf_hit) ? {leaf_word[WORD_W-1 -: PPN_W], lk_offset} : '0;
         rsp_entry     <= (lk_valid && leaf_hit) ? leaf_word : '0;
         rsp_dir_entry <= (lk_valid && !leaf_hit && dir_hit) ? dir_word : '0;
      end
   end

   logic unused_ok;
   assign unused_ok = ^{dir_way, fill_mword};
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk
   import tlb_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [OFS_W-1:0]  lk_offset,
   input logic              flush_all,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic              rsp_need_dir,
   input logic [WORD_W-1:0] rsp_paddr
);
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid); // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss)); // R2
   AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit ^ rsp_miss)); // R2
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(lk_offset))); // R3
   AST_DIR_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_need_dir |-> rsp_miss); // R4
   AST_FULL_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && $past(flush_all)) |=> (rsp_miss && rsp_need_dir)); // R9
endmodule

bind tlb_sa tlb_sa_chk i_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_offset(lk_offset),
   .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
   .rsp_miss(rsp_miss), .rsp_need_dir(rsp_need_dir), .rsp_paddr(rsp_paddr));

// File: tb/test_tlb_sa.sv
module test_tlb_sa;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, fill_valid = 1'b0, fill_is_dir = 1'b0;
   logic        flush_ctx = 1'b0, flush_all = 1'b0;
   logic [19:0] lk_vpn = '0, fill_vpn = '0;
   logic [11:0] lk_offset = '0;
   logic [31:0] fill_entry = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_need_dir;
   logic [31:0] rsp_paddr, rsp_entry, rsp_dir_entry;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_sa i_tlb_sa (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
      .lk_offset(lk_offset), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
      .fill_is_dir(fill_is_dir), .fill_entry(fill_entry), .flush_ctx(flush_ctx),
      .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_need_dir(rsp_need_dir), .rsp_paddr(rsp_paddr),
      .rsp_entry(rsp_entry), .rsp_dir_entry(rsp_dir_entry));

   int total = 0;
   int bad   = 0;

   // reference model
   bit          m_v [16][4];
   bit          m_d [16][4];
   int          m_t [16][4];
   logic [31:0] m_w [16][4];
   bit   [2:0]  m_p [16];

   bit          e_valid, e_hit, e_miss, e_nd, e_pend;
   logic [31:0] e_paddr, e_entry, e_dent;
   string       e_tag;

   function automatic int kidx(logic [19:0] v, bit d);
      return d ? int'(v[13:10]) : int'(v[3:0]);
   endfunction
   function automatic int ktag(logic [19:0] v, bit d);
      return d ? int'(v[19:14]) : int'(v[19:4]);
   endfunction
   function automatic int mfind(int s, bit d, int t);
      for (int w = 0; w < 4; w++)
         if (m_v[s][w] && m_d[s][w] == d && m_t[s][w] == t) return w;
      return -1;
   endfunction
   function automatic int mvictim(bit [2:0] p);
      return p[0] ? (p[2] ? 3 : 2) : (p[1] ? 1 : 0);
   endfunction
   function automatic bit [2:0] mtouch(bit [2:0] p, int w);
      bit [2:0] n = p;
      n[0] = (w < 2);
      if (w < 2) n[1] = (w == 0); else n[2] = (w == 2);
      return n;
   endfunction

   task automatic check_rsp();
      total++;
      if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_miss !== e_miss ||
          rsp_need_dir !== e_nd || rsp_paddr !== e_paddr || rsp_entry !== e_entry ||
          rsp_dir_entry !== e_dent) begin
         bad++;
         $display("FAIL %s: actual v=%0b h=%0b m=%0b nd=%0b pa=%h ent=%h dent=%h expected v=%0b h=%0b m=%0b nd=%0b pa=%h ent=%h dent=%h",
                  e_tag, rsp_valid, rsp_hit, rsp_miss, rsp_need_dir, rsp_paddr, rsp_entry,
                  rsp_dir_entry, e_valid, e_hit, e_miss, e_nd, e_paddr, e_entry, e_dent);
      end
   endtask

   task automatic step(string tag, bit lv, logic [19:0] vpn, logic [11:0] ofs,
                       bit fv, logic [19:0] fvpn, bit fd, logic [31:0] fw,
                       bit fc, bit fa);
      int li, lw, di, dw, fi, ft, fwy;
      bit fok;
      @(negedge clk);
      if (e_pend) check_rsp();
      lk_valid = lv; lk_vpn = vpn; lk_offset = ofs;
      fill_valid = fv; fill_vpn = fvpn; fill_is_dir = fd; fill_entry = fw;
      flush_ctx = fc; flush_all = fa;
      li = kidx(vpn, 0); lw = mfind(li, 0, ktag(vpn, 0));
      di = kidx(vpn, 1); dw = mfind(di, 1, ktag(vpn, 1));
      e_tag   = tag;
      e_valid = lv;
      e_hit   = lv && lw >= 0;
      e_miss  = lv && lw < 0;
      e_nd    = e_miss && dw < 0;
      e_paddr = e_hit ? {m_w[li][lw][31:12], ofs} : 32'h0;
      e_entry = e_hit ? m_w[li][lw] : 32'h0;
      e_dent  = (e_miss && dw >= 0) ? m_w[di][dw] : 32'h0;
      e_pend  = 1'b1;
      fok = fv && !fc && !fa;
      fi = kidx(fvpn, fd); ft = ktag(fvpn, fd);
      fwy = mfind(fi, fd, ft);
      if (fwy < 0)
         for (int w = 3; w >= 0; w--) if (!m_v[fi][w]) fwy = w;
      if (fwy < 0) fwy = mvictim(m_p[fi]);
      if (fa) begin
         for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_v[s][w] = 0;
      end else if (fc) begin
         for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++)
            m_v[s][w] = m_v[s][w] && m_w[s][w][8];
      end else if (fv) begin
         m_v[fi][fwy] = 1; m_d[fi][fwy] = fd; m_t[fi][fwy] = ft; m_w[fi][fwy] = fw;
      end
      if (fok) m_p[fi] = mtouch(m_p[fi], fwy);
      if (e_hit && !(fok && fi == li)) m_p[li] = mtouch(m_p[li], lw);
   endtask

   task automatic look(string tag, logic [19:0] vpn, logic [11:0] ofs);
      step(tag, 1, vpn, ofs, 0, 20'h0, 0, 32'h0, 0, 0);
   endtask
   task automatic fill(string tag, logic [19:0] vpn, bit d, logic [31:0] w);
      step(tag, 0, 20'h0, 12'h0, 1, vpn, d, w, 0, 0);
   endtask

   function automatic logic [19:0] rnd_vpn();
      logic [15:0] t;
      t = 16'($urandom % 4) | 16'(($urandom % 3) << 6);
      return {t, 4'($urandom % 3)};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      e_pend = 0;
      for (int s = 0; s < 16; s++) begin
         m_p[s] = 0;
         for (int w = 0; w < 4; w++) begin
            m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; m_w[s][w] = 0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state at the outputs
      e_valid = 0; e_hit = 0; e_miss = 0; e_nd = 0; e_paddr = 0; e_entry = 0; e_dent = 0;
      e_tag = "R11 reset outputs";
      check_rsp();
      look("R11 empty after reset", 20'h12345, 12'habc);
      // R5 / R3: fill directory and leaf, then hit
      fill("R5 dir fill", 20'h12345, 1, 32'h000AA001);
      fill("R5 leaf fill", 20'h12345, 0, 32'h55555003);
      look("R3 hit paddr", 20'h12345, 12'habc);
      // R4: leaf miss under a cached directory, and miss with no directory
      look("R4 dir cached", 20'h12346, 12'h010);
      look("R4 dir absent", 20'h00005, 12'h020);
      // R6 / R7: overfill set 3 and observe eviction
      for (int i = 1; i <= 5; i++)
         fill("R6 set fill", {16'(i), 4'h3}, 0, {20'(i * 16'h111), 12'h001});
      for (int i = 1; i <= 5; i++) look("R6 evict order", {16'(i), 4'h3}, 12'(i));
      look("R7 hit touch", 20'h00033, 12'h0);
      fill("R7 after touch", 20'h00063, 0, 32'hABCDE001);
      for (int i = 1; i <= 6; i++) look("R7 evict after touch", {16'(i), 4'h3}, 12'h5);
      // R5: refill the same key overwrites in place
      fill("R5 overwrite", 20'h12345, 0, 32'h77777003);
      look("R5 overwrite read", 20'h12345, 12'h111);
      // R1: same tag different sets, same set different tag
      fill("R1 set a", 20'h00AB1, 0, 32'h11111001);
      fill("R1 set b", 20'h00AB2, 0, 32'h22222001);
      look("R1 idx a", 20'h00AB1, 12'h1);
      look("R1 idx b", 20'h00AB2, 12'h2);
      look("R1 tag diff", 20'h01AB1, 12'h3);
      // R8: context flush keeps global
      fill("R8 global", 20'h00017, 0, 32'h33333101);
      fill("R8 local", 20'h00027, 0, 32'h44444001);
      step("R8 flush ctx", 0, 20'h0, 12'h0, 0, 20'h0, 0, 32'h0, 1, 0);
      look("R8 global kept", 20'h00017, 12'h4);
      look("R8 local gone", 20'h00027, 12'h5);
      // R10: fill dropped under flush; lookup sees pre-edge state
      step("R10 fill vs flush", 1, 20'h00017, 12'h6, 1, 20'h00037, 0, 32'h66666001, 1, 0);
      look("R10 dropped fill", 20'h00037, 12'h7);
      step("R10 look with fill", 1, 20'h00047, 12'h8, 1, 20'h00047, 0, 32'h88888001, 0, 0);
      look("R10 fill visible", 20'h00047, 12'h9);
      // R9: full flush removes global too
      step("R9 flush all", 0, 20'h0, 12'h0, 0, 20'h0, 0, 32'h0, 0, 1);
      look("R9 global gone", 20'h00017, 12'ha);
      // R6: after flush the invalid ways are used first
      fill("R6 invalid first", 20'h00107, 0, 32'h9999A001);
      look("R6 refill read", 20'h00107, 12'hb);
      // random mix: R1 R6 R7
      for (int n = 0; n < 4000; n++) begin
         bit lv, fv, fd, fc, fa;
         lv = ($urandom % 4) != 0;
         fv = ($urandom % 3) == 0;
         fd = ($urandom % 4) == 0;
         fc = ($urandom % 60) == 0;
         fa = ($urandom % 200) == 0;
         step("R1 R6 R7 random", lv, rnd_vpn(), 12'($urandom), fv, rnd_vpn(), fd,
              $urandom, fc, fa);
      end
      step("R2 idle", 0, 20'h0, 12'h0, 0, 20'h0, 0, 32'h0, 0, 0);
      @(negedge clk);
      check_rsp();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule